// File: doc/BRIEF.md
# Flash Region Lock and Security Unit

This block decides whether each flash write or page-erase command may go ahead. It keeps sixteen region lock bits. Each bit guards one sixteenth of the page space. A separate boot-page guard covers the lowest pages of the array. A device security flag blocks every command except a full chip wipe while it is set. The block also runs the chip-erase sequence. It first wipes the on-chip volatile memories, then erases the flash array, and finally clears the security flag and every lock bit.

Commands arrive on a valid/ready stream. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for the whole of a chip erase, so the sender must keep `cmd_op` and `cmd_page` stable until the command is taken. Every command that is taken gets one verdict pulse on the cycle after it is taken. The verdict pulse cannot be back-pressured. Page numbers are `PAGE_W` bits wide. The region index is the top four bits of the page number.

Top module: `flash_guard`

## Requirements
- R1: For a write (op 1) or page erase (op 2), the region index is the top four bits of `cmd_page`. If that region's lock bit is set, the command is denied (`rsp_grant`=0). Otherwise it is granted, subject to R3 and R5.
- R2: A lock command (op 3) sets the lock bit of the region that holds `cmd_page`. An unlock command (op 4) clears that bit. No other bit changes, and `lock_map` shows the new value on the cycle after the command is taken.
- R3: While `cfg_boot_prot` is 1, a write or page erase to a page below `cfg_boot_pages` is denied, even if its region is unlocked. Pages at or above that bound are not affected by this guard.
- R4: A write or page erase that is denied by R1 or R3 sets `lock_err` on the next cycle. The flag stays set until a cycle with `err_clr`=1, and it reads 0 after that cycle. If a new violation arrives in the same cycle as `err_clr`, the flag stays set.
- R5: A secure command (op 5) sets `sec_active`. While `sec_active` is 1, every command other than chip erase is denied, including the external read request (op 7), which is otherwise always granted. A denial that comes only from security does not set `lock_err`.
- R6: A chip erase raises `vol_erase_req` until a cycle with `vol_done`=1. It then raises `flash_erase_req` until a cycle with `flash_done`=1. One cycle later, `sec_active` and all of `lock_map` read 0 and `ce_busy` falls. The two requests are never high together.
- R7: A chip erase (op 6) is always granted, whatever the lock bits, boot guard and security flag hold.
- R8: `cmd_ready` is low from the cycle after a chip erase is taken until the sequence ends. No command is taken during that time, and no verdict is produced for it.
- R9: Each command that is taken yields exactly one `rsp_valid` pulse on the next cycle. Op 0 (no operation) is granted unless secure.
- R10: After reset, `lock_map` is 0, `sec_active` is 0, `lock_err` is 0, both erase requests are 0, `ce_busy` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (low during chip erase) |
| cmd_op | input | 3 | Command code (0 nop, 1 write, 2 erase, 3 lock, 4 unlock, 5 secure, 6 chip erase, 7 external read) |
| cmd_page | input | PAGE_W | Target page number |
| rsp_valid | output | 1 | Verdict pulse for the command taken last cycle |
| rsp_grant | output | 1 | 1 = command permitted, 0 = denied |
| cfg_boot_prot | input | 1 | Enables the boot-page guard |
| cfg_boot_pages | input | PAGE_W | Number of guarded boot pages from page 0 |
| err_clr | input | 1 | Read-clear pulse for the lock error flag |
| lock_err | output | 1 | Sticky lock violation flag |
| lock_map | output | 16 | Current region lock bits |
| sec_active | output | 1 | Device security flag |
| vol_done | input | 1 | Volatile wipe finished |
| flash_done | input | 1 | Flash array erase finished |
| vol_erase_req | output | 1 | Volatile wipe request |
| flash_erase_req | output | 1 | Flash array erase request |
| ce_busy | output | 1 | Chip erase in progress |

## Verification
A wrong lock bit shows on `lock_map` one cycle after the lock command that caused it. It also shows in the next verdict for a page in that region. A security flag that sticks or fails to clear appears on `sec_active` and turns the next verdict to a denial. A chip-erase state that is out of step shows up within a cycle, because the requests, `ce_busy` and `cmd_ready` stop matching the handshake that was given. The reference model compares every output on every clock, so a fault is reported at the cycle where it first becomes visible.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_WRITE      = 3'd1,
    OP_ERASE      = 3'd2,
    OP_LOCK       = 3'd3,
    OP_UNLOCK     = 3'd4,
    OP_SECURE     = 3'd5,
    OP_CHIP_ERASE = 3'd6,
    OP_EXT_READ   = 3'd7
  } fg_op_e;

  typedef enum logic [1:0] {
    CE_IDLE   = 2'd0,
    CE_VOL    = 2'd1,
    CE_FLASH  = 2'd2,
    CE_FINISH = 2'd3
  } ce_state_e;
endpackage

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int NREG  = 16,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic [REG_W-1:0] wr_idx,
  input  logic             clear_all,
  output logic [NREG-1:0]  locks
);
  for (genvar g = 0; g < NREG; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        locks[g] <= 1'b0;
      else if (clear_all)
        locks[g] <= 1'b0;
      else if (wr_en && (wr_idx == REG_W'(g)))
        locks[g] <= wr_val;
    end
  end
endmodule

// File: rtl/fg_access_check.sv
module fg_access_check
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int NREG   = 16,
  parameter int REG_W  = $clog2(NREG)
) (
  input  fg_op_e            op,
  input  logic [PAGE_W-1:0] page,
  input  logic [NREG-1:0]   locks,
  input  logic              secure,
  input  logic              boot_prot,
  input  logic [PAGE_W-1:0] boot_pages,
  output logic [REG_W-1:0]  region,
  output logic              grant,
  output logic              violation
);
  logic region_locked;
  logic boot_hit;

  assign region        = page[PAGE_W-1 -: REG_W];
  assign region_locked = locks[region];
  assign boot_hit      = boot_prot && (page < boot_pages);

  always_comb begin
    violation = 1'b0;
    grant     = !secure;
    unique case (op)
      OP_WRITE, OP_ERASE: begin
        violation = region_locked || boot_hit;
        grant     = !violation && !secure;
      end
      OP_CHIP_ERASE: grant = 1'b1;
      default: grant = !secure;
    endcase
  end
endmodule

// File: rtl/fg_erase_seq.sv
module fg_erase_seq
  import flash_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic vol_done,
  input  logic flash_done,
  output logic vol_req,
  output logic flash_req,
  output logic busy,
  output logic wipe
);
  ce_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CE_IDLE:   if (start) st_d = CE_VOL;
      CE_VOL:    if (vol_done) st_d = CE_FLASH;
      CE_FLASH:  if (flash_done) st_d = CE_FINISH;
      CE_FINISH: st_d = CE_IDLE;
      default:   st_d = CE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CE_IDLE;
    else        st_q <= st_d;
  end

  assign vol_req   = (st_q == CE_VOL);
  assign flash_req = (st_q == CE_FLASH);
  assign busy      = (st_q != CE_IDLE);
  assign wipe      = (st_q == CE_FINISH);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int NREG   = 16,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  output logic              rsp_valid,
  output logic              rsp_grant,
  input  logic              cfg_boot_prot,
  input  logic [PAGE_W-1:0] cfg_boot_pages,
  input  logic              err_clr,
  output logic              lock_err,
  output logic [NREG-1:0]   lock_map,
  output logic              sec_active,
  input  logic              vol_done,
  input  logic              flash_done,
  output logic              vol_erase_req,
  output logic              flash_erase_req,
  output logic              ce_busy
);
  fg_op_e           op;
  logic             accept;
  logic             grant;
  logic             violation;
  logic [REG_W-1:0] region;
  logic             wipe;
  logic             lock_wr;
  logic             rsp_v_q, rsp_g_q, err_q, sec_q;

  assign op        = fg_op_e'(cmd_op);
  assign cmd_ready = !ce_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign lock_wr   = accept && grant && (op == OP_LOCK || op == OP_UNLOCK);

  fg_access_check #(.PAGE_W(PAGE_W), .NREG(NREG)) u_check (
    .op(op), .page(cmd_page), .locks(lock_map), .secure(sec_q),
    .boot_prot(cfg_boot_prot), .boot_pages(cfg_boot_pages),
    .region(region), .grant(grant), .violation(violation)
  );

  fg_lock_bank #(.NREG(NREG)) u_locks (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr), .wr_val(op == OP_LOCK),
    .wr_idx(region), .clear_all(wipe), .locks(lock_map)
  );

  fg_erase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && op == OP_CHIP_ERASE),
    .vol_done(vol_done), .flash_done(flash_done),
    .vol_req(vol_erase_req), .flash_req(flash_erase_req),
    .busy(ce_busy), .wipe(wipe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_g_q <= 1'b0;
      err_q   <= 1'b0;
      sec_q   <= 1'b0;
    end else begin
      rsp_v_q <= accept;
      if (accept) rsp_g_q <= grant;
      if (accept && violation)  err_q <= 1'b1;
      else if (err_clr)         err_q <= 1'b0;
      if (wipe)                                       sec_q <= 1'b0;
      else if (accept && grant && op == OP_SECURE)   sec_q <= 1'b1;
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_grant  = rsp_g_q;
  assign lock_err   = err_q;
  assign sec_active = sec_q;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic            err_clr,
  input logic            lock_err,
  input logic [NREG-1:0] lock_map,
  input logic            sec_active,
  input logic            vol_erase_req,
  input logic            flash_erase_req,
  input logic            ce_busy
);
  AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid); // R9
  AST_NO_RSP_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid); // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vol_erase_req && flash_erase_req)); // R6
  AST_VOL_BEFORE_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_erase_req) |-> $past(vol_erase_req)); // R6
  AST_WIPE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_busy) |-> (lock_map == '0 && !sec_active)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err && !err_clr) |=> lock_err); // R4
  AST_SECURE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && sec_active && cmd_op != 3'd6) |=> (rsp_valid && !rsp_grant)); // R5
  AST_CHIP_ERASE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd6) |=> rsp_grant); // R7
endmodule

bind flash_guard flash_guard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
  .err_clr(err_clr), .lock_err(lock_err), .lock_map(lock_map),
  .sec_active(sec_active), .vol_erase_req(vol_erase_req),
  .flash_erase_req(flash_erase_req), .ce_busy(ce_busy)
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int PW = 9;
  localparam int SH = PW - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [PW-1:0] cmd_page = '0;
  logic cfg_boot_prot = 1'b0;
  logic [PW-1:0] cfg_boot_pages = '0;
  logic err_clr = 1'b0, vol_done = 1'b0, flash_done = 1'b0;
  logic cmd_ready, rsp_valid, rsp_grant, lock_err, sec_active;
  logic vol_erase_req, flash_erase_req, ce_busy;
  logic [15:0] lock_map;

  int n_tests = 0, n_fail = 0, cycles = 0;

  // reference model state
  bit [15:0] m_locks;
  bit m_sec, m_err, m_rv, m_rg;
  int m_ce;

  always #2 clk = ~clk;

  flash_guard #(.PAGE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_page(cmd_page), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .cfg_boot_prot(cfg_boot_prot), .cfg_boot_pages(cfg_boot_pages),
    .err_clr(err_clr), .lock_err(lock_err), .lock_map(lock_map), .sec_active(sec_active),
    .vol_done(vol_done), .flash_done(flash_done), .vol_erase_req(vol_erase_req),
    .flash_erase_req(flash_erase_req), .ce_busy(ce_busy)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locks = '0; m_sec = 0; m_err = 0; m_rv = 0; m_rg = 0; m_ce = 0;
    end else begin
      bit take, g, viol;
      int reg_i;
      take = cmd_valid && (m_ce == 0);
      reg_i = int'(cmd_page) >> SH;
      viol = 0;
      g = !m_sec;
      if (cmd_op == 3'd1 || cmd_op == 3'd2) begin
        viol = m_locks[reg_i] || (cfg_boot_prot && cmd_page < cfg_boot_pages);
        g = !viol && !m_sec;
      end else if (cmd_op == 3'd6) g = 1;
      m_rv = take;
      if (take) m_rg = g;
      if (take && viol) m_err = 1;
      else if (err_clr) m_err = 0;
      case (m_ce)
        1: if (vol_done) m_ce = 2;
        2: if (flash_done) m_ce = 3;
        3: begin m_ce = 0; m_sec = 0; m_locks = '0; end
        default: ;
      endcase
      if (take && g) begin
        if (cmd_op == 3'd3) m_locks[reg_i] = 1;
        if (cmd_op == 3'd4) m_locks[reg_i] = 0;
        if (cmd_op == 3'd5) m_sec = 1;
        if (cmd_op == 3'd6) m_ce = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 lock_map", lock_map, m_locks);
      chk("R4 lock_err", lock_err, m_err);
      chk("R5 sec_active", sec_active, m_sec);
      chk("R6 vol_erase_req", vol_erase_req, m_ce == 1);
      chk("R6 flash_erase_req", flash_erase_req, m_ce == 2);
      chk("R6 ce_busy", ce_busy, m_ce != 0);
      chk("R8 cmd_ready", cmd_ready, m_ce == 0);
      chk("R9 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R1 rsp_grant", rsp_grant, m_rg);
    end
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [2:0] op, input int page, input bit exp_g, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_page = PW'(page);
    @(negedge clk);
    cmd_valid = 0;
    chk({tag, " verdict valid"}, rsp_valid, 1);
    chk({tag, " verdict"}, rsp_grant, exp_g);
  endtask

  task automatic pulse_done(input bit vol);
    @(negedge clk);
    if (vol) vol_done = 1; else flash_done = 1;
    @(negedge clk);
    vol_done = 0; flash_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 lock_map", lock_map, 0);
    chk("R10 sec", sec_active, 0);
    chk("R10 err", lock_err, 0);
    chk("R10 reqs", {vol_erase_req, flash_erase_req, ce_busy}, 0);
    chk("R10 ready", cmd_ready, 1);
    rst_n = 1;
    send(3'd1, 5, 1, "R1 write unlocked");
    send(3'd3, 'h40, 1, "R2 lock region 2");
    chk("R2 map", lock_map, 16'h0004);
    send(3'd1, 'h45, 0, "R1 write locked");
    chk("R4 err set", lock_err, 1);
    send(3'd2, 'h20, 1, "R1 erase neighbour");
    chk("R4 err held", lock_err, 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk("R4 err cleared", lock_err, 0);
    send(3'd4, 'h5F, 1, "R2 unlock region 2");
    send(3'd1, 'h45, 1, "R2 write after unlock");
    cfg_boot_prot = 1; cfg_boot_pages = 8;
    send(3'd1, 3, 0, "R3 boot page write");
    send(3'd1, 8, 1, "R3 above boot bound");
    send(3'd2, 7, 0, "R3 boot page erase");
    // violation and clear in the same cycle: set wins (R4)
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd1; cmd_page = 2; err_clr = 1;
    @(negedge clk); cmd_valid = 0; err_clr = 0;
    chk("R4 set wins", lock_err, 1);
    send(3'd3, 'h1F0, 1, "R2 lock region 15");
    send(3'd2, 'h1FF, 0, "R1 erase top region");
    send(3'd7, 0, 1, "R5 ext read open");
    send(3'd0, 0, 1, "R9 nop");
    send(3'd5, 0, 1, "R5 secure");
    send(3'd1, 'h20, 0, "R5 write secured");
    send(3'd7, 0, 0, "R5 ext read secured");
    send(3'd3, 'h20, 0, "R5 lock secured");
    send(3'd6, 0, 1, "R7 chip erase");
    // hold a command while busy: must not be taken (R8)
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd1; cmd_page = 'h30;
    repeat (3) @(negedge clk);
    chk("R8 stalled no verdict", rsp_valid, 0);
    chk("R6 vol req first", vol_erase_req, 1);
    pulse_done(0);
    chk("R6 flash_done ignored in vol stage", vol_erase_req, 1);
    pulse_done(1);
    chk("R6 flash req", flash_erase_req, 1);
    pulse_done(0);
    pulse_done(1);
    chk("R6 wiped locks", lock_map, 0);
    chk("R6 security cleared", sec_active, 0);
    @(negedge clk); cmd_valid = 0;
    cfg_boot_prot = 0;
    send(3'd2, 'h1FF, 1, "R6 erase after wipe");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule